// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block steps a single external bus access through its phases. The first phase is a setup cycle (T1). Next come zero or more software wait cycles (Tw), whose count a configuration input sets. The access ends with a completion cycle (T2). When the software count is nonzero, an active-low wait input from the external device can hold the access in Tw past the programmed count. That input is looked at only once the last programmed Tw is reached.

The wait input can be sampled on the rising clock edge or, when a select input is set, on the falling edge in the middle of the cycle. In falling-edge mode the device side can flag that sample as invalid. The sample is then discarded and the decision waits for the next falling edge. Three access qualifiers cause the wait input to be disregarded: a 16-byte DMA write to external space in dual-address mode, a 16-byte single-address DMA from an acknowledged device, and a cache write-back. The configuration and the qualifiers are captured when a request is accepted. A one-cycle done pulse in T2 tells the requester that the access is complete.

Top module: `bus_wait_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `phase_o` is 0 (idle), and `strobe_o` and `done_o` are low.
- R2: `phase_o` encodes the phases as 0 idle, 1 T1, 2 Tw, 3 T2. A request seen in idle gives T1 on the next cycle. A request seen in any other phase has no effect.
- R3: With a wait count N of 1 or more and the wait input high, the access runs one T1 cycle, exactly N Tw cycles, and then one T2 cycle.
- R4: With a wait count of zero, T1 is followed directly by T2, and the wait input has no effect.
- R5: A low wait input during T1 or during any Tw before the last one does not lengthen the access.
- R6: A low sample at the last Tw adds one more Tw. The input is sampled again in each added Tw, and T2 follows the first Tw whose sample is high.
- R7: When falling-edge mode is selected, the decision uses the value present at the falling edge within the Tw. Otherwise it uses the value present at the rising edge that ends the Tw.
- R8: In falling-edge mode, a high invalid-sample flag at that falling edge adds one Tw, and the next falling edge is sampled instead. In rising-edge mode the flag has no effect.
- R9: If any of the three ignore qualifiers is high when the request is accepted, the wait input has no effect, and the access ends after exactly N Tw cycles.
- R10: `done_o` is high for exactly one cycle, during T2, and idle follows. `strobe_o` is high from T1 through T2.
- R11: The wait count, the sampling-edge select and the qualifiers are captured when the request is accepted. Later changes to them do not affect the access already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, accepted only in idle |
| sw_wait_i | input | SW_W | Programmed software wait count |
| wait_fall_sel_i | input | 1 | 1 = sample the wait input on the falling edge |
| wait_ni | input | 1 | External wait, active low |
| wait_late_i | input | 1 | Falling-edge sample is invalid; use the next one |
| dma_dual_wr16_i | input | 1 | Qualifier: 16-byte dual-address DMA write to external space |
| dma_single_ack16_i | input | 1 | Qualifier: 16-byte single-address DMA from an acknowledged device |
| cache_wb_i | input | 1 | Qualifier: cache write-back access |
| phase_o | output | 2 | Current phase: 0 idle, 1 T1, 2 Tw, 3 T2 |
| strobe_o | output | 1 | Access active (T1 through T2) |
| done_o | output | 1 | Access complete, one cycle in T2 |

## Verification
The assertions assume that the wait input and the invalid-sample flag are stable around both clock edges. This holds because the bench changes each input only at fixed points, away from either edge. The first value of the wait input is applied two time units after the rising edge, and a second value after the falling edge. This lets the bench feed different values to the two sampling points in the same cycle, which is how falling-edge and rising-edge sampling are told apart. The assertions also assume that the qualifiers and the wait count are valid whenever a request is raised in idle. The bench holds them steady from the cycle the request is raised and changes them only while an access is running, to check that they are captured.

// File: rtl/bus_wait_pkg.sv
package bus_wait_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_TW   = 2'd2,
    PH_T2   = 2'd3
  } phase_e;
endpackage

// File: rtl/bus_wait_count.sv
module bus_wait_count #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_dec_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> !zero_o);
endmodule

// File: rtl/bus_wait_sample.sv
module bus_wait_sample (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_sel_i,
  input  logic wait_ni,
  input  logic late_i,
  output logic stretch_o,
  output logic late_hold_o
);
  logic fall_wait_q, fall_late_q;

  // mid-cycle capture for falling-edge mode
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_wait_q <= 1'b1;
      fall_late_q <= 1'b0;
    end else begin
      fall_wait_q <= wait_ni;
      fall_late_q <= late_i;
    end
  end

  assign stretch_o   = fall_sel_i ? (fall_late_q | ~fall_wait_q) : ~wait_ni;
  assign late_hold_o = fall_late_q;
endmodule

// File: rtl/bus_wait_fsm.sv
module bus_wait_fsm
  import bus_wait_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   fall_sel_i,
  input  logic   ign_i,
  input  logic   zero_i,
  input  logic   stretch_i,
  output logic   load_o,
  output logic   dec_o,
  output logic   fall_o,
  output logic   ign_o,
  output phase_e phase_o
);
  phase_e state_q, state_d;
  logic   fall_q, ign_q;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    dec_o   = 1'b0;
    unique case (state_q)
      PH_IDLE: if (req_i) begin
        load_o  = 1'b1;
        state_d = PH_T1;
      end
      PH_T1: if (zero_i) state_d = PH_T2;
             else begin
               dec_o   = 1'b1;
               state_d = PH_TW;
             end
      PH_TW: if (!zero_i)                 dec_o   = 1'b1;
             else if (ign_q || !stretch_i) state_d = PH_T2;
      PH_T2: state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      fall_q  <= 1'b0;
      ign_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        fall_q <= fall_sel_i;
        ign_q  <= ign_i;
      end
    end
  end

  assign phase_o = state_q;
  assign fall_o  = fall_q;
  assign ign_o   = ign_q;

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_IDLE && req_i) |=> state_q == PH_T1);
  assert_busy_no_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_T1) |=> (state_q == PH_TW || state_q == PH_T2));
  assert_zero_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_T1 && zero_i) |=> state_q == PH_T2);
  assert_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_TW && zero_i && ign_q) |=> state_q == PH_T2);
  assert_stretch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_TW && zero_i && !ign_q && stretch_i) |=> state_q == PH_TW);
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bus_wait_pkg::*;
#(
  parameter int SW_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [SW_W-1:0] sw_wait_i,
  input  logic            wait_fall_sel_i,
  input  logic            wait_ni,
  input  logic            wait_late_i,
  input  logic            dma_dual_wr16_i,
  input  logic            dma_single_ack16_i,
  input  logic            cache_wb_i,
  output logic [1:0]      phase_o,
  output logic            strobe_o,
  output logic            done_o
);
  logic   load, dec, zero, stretch, late_hold, fall, ign;
  phase_e phase;

  bus_wait_count #(.W(SW_W)) i_count (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (load), .val_i (sw_wait_i),
    .dec_i (dec), .zero_o (zero)
  );

  bus_wait_sample i_sample (
    .clk_i (clk_i), .rst_ni (rst_ni), .fall_sel_i (fall), .wait_ni (wait_ni),
    .late_i (wait_late_i), .stretch_o (stretch), .late_hold_o (late_hold)
  );

  bus_wait_fsm i_fsm (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req_i),
    .fall_sel_i (wait_fall_sel_i),
    .ign_i (dma_dual_wr16_i | dma_single_ack16_i | cache_wb_i),
    .zero_i (zero), .stretch_i (stretch), .load_o (load), .dec_o (dec),
    .fall_o (fall), .ign_o (ign), .phase_o (phase)
  );

  assign phase_o  = phase;
  assign strobe_o = (phase != PH_IDLE);
  assign done_o   = (phase == PH_T2);

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && phase_o == 2'd0));
  assert_late_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_TW && zero && !ign && fall && late_hold) |=> phase_o == 2'd2);
  assert_rise_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_TW && zero && !ign && !fall && wait_ni) |=> phase_o == 2'd3);
endmodule

// File: tb/test_bus_wait_ctrl.sv
module test_bus_wait_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [3:0] sw = '0;
  logic       fsel = 1'b0, wn = 1'b1, late = 1'b0;
  logic       q_dual = 1'b0, q_single = 1'b0, q_wb = 1'b0;
  logic [1:0] phase;
  logic       strobe, done;
  bit         wa = 1'b1, wb = 1'b1;

  int errors = 0, checks = 0;
  int m_state = 0, m_cnt = 0;
  bit m_ign = 0, m_fall = 0, finished = 0;

  always #5 clk = ~clk;

  bus_wait_ctrl #(.SW_W(4)) i_bus_wait_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .sw_wait_i (sw),
    .wait_fall_sel_i (fsel), .wait_ni (wn), .wait_late_i (late),
    .dma_dual_wr16_i (q_dual), .dma_single_ack16_i (q_single), .cache_wb_i (q_wb),
    .phase_o (phase), .strobe_o (strobe), .done_o (done)
  );

  task automatic chk(string tag);
    checks++;
    if (phase !== 2'(m_state) || strobe !== (m_state != 0) || done !== (m_state == 3)) begin
      errors++;
      $display("FAIL %s: phase/strobe/done=%0d/%0b/%0b expected %0d/%0b/%0b",
               tag, phase, strobe, done, m_state, m_state != 0, m_state == 3);
    end
  endtask

  task automatic model();
    case (m_state)
      0: if (req) begin
           m_state = 1; m_cnt = int'(sw);
           m_ign = q_dual | q_single | q_wb; m_fall = fsel;
         end
      1: if (m_cnt == 0) m_state = 3; else begin m_cnt--; m_state = 2; end
      2: if (m_cnt > 0) m_cnt--;
         else if (m_ign) m_state = 3;
         else if (!(m_fall ? (late || !wa) : !wb)) m_state = 3;
      default: m_state = 0;
    endcase
  endtask

  // one cycle: wa before the falling edge, wb after it
  task automatic step(string tag, int n = 1);
    for (int i = 0; i < n; i++) begin
      wn = wa; #5; wn = wb;
      @(posedge clk);
      model();
      #1 chk(tag);
      #1;
    end
  endtask

  task automatic go(string tag, int n_sw, bit f, bit [2:0] q);
    sw = 4'(n_sw); fsel = f; {q_dual, q_single, q_wb} = q; req = 1'b1;
    step(tag);
    req = 1'b0;
  endtask

  task automatic drain(string tag);
    wa = 1; wb = 1; late = 0;
    for (int i = 0; i < 40 && m_state != 0; i++) step(tag);
    step(tag);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: finished=0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset
    #2; chk("R1 in reset");
    @(posedge clk); #1 chk("R1 in reset"); #1;
    rst_n = 1'b1;
    step("R1 after reset", 2);

    // R3 plain 2-wait access, R10 strobe/done
    go("R3 accept", 2, 0, 3'b000);
    step("R3 R10 sequence", 4);
    // R4 zero wait, wait low throughout
    wa = 0; wb = 0;
    go("R4 accept", 0, 0, 3'b000);
    step("R4 zero wait", 3);
    wa = 1; wb = 1;
    // R5 early lows have no effect
    wa = 0; wb = 0;
    go("R5 accept", 3, 0, 3'b000);
    step("R5 early low", 3);
    wa = 1; wb = 1;
    drain("R5 finish");
    // R6 stretch in rising mode
    go("R6 accept", 2, 0, 3'b000);
    step("R6 pre", 2);
    wa = 0; wb = 0;
    step("R6 stretch", 3);
    drain("R6 release");
    // R7 falling mode: mid-cycle high, edge low -> no stretch
    go("R7 accept", 1, 1, 3'b000);
    step("R7 pre");
    wa = 1; wb = 0; step("R7 falling uses mid-cycle");
    drain("R7 finish");
    // R7 rising mode with same pattern -> stretch
    go("R7 accept rise", 1, 0, 3'b000);
    step("R7 pre rise");
    wa = 1; wb = 0; step("R7 rising uses edge", 2);
    drain("R7 finish rise");
    // R7 falling mode: mid low, edge high -> stretch
    go("R7 accept fall2", 1, 1, 3'b000);
    step("R7 pre fall2");
    wa = 0; wb = 1; step("R7 falling mid low", 2);
    drain("R7 finish fall2");
    // R8 late flag in falling mode
    go("R8 accept", 1, 1, 3'b000);
    step("R8 pre");
    late = 1; step("R8 late defers");
    late = 0; step("R8 resample", 2);
    drain("R8 finish");
    // R8 late flag ignored in rising mode
    go("R8 accept rise", 1, 0, 3'b000);
    step("R8 pre rise");
    late = 1; step("R8 rising ignores flag", 2);
    drain("R8 finish rise");
    // R9 each qualifier disables wait
    for (int k = 0; k < 3; k++) begin
      wa = 0; wb = 0;
      go("R9 accept", 2, k[0], 3'b001 << k);
      {q_dual, q_single, q_wb} = 3'b000;
      step("R9 wait ignored", 4);
      drain("R9 finish");
    end
    // R2 request during access ignored, R11 config captured
    go("R11 accept", 1, 0, 3'b000);
    req = 1; sw = 4'd5; fsel = 1; q_wb = 1;
    step("R11 R2 busy request", 1);
    req = 0; q_wb = 0;
    wa = 0; wb = 1;
    step("R11 captured config", 3);
    drain("R2 finish");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule